// File: doc/BRIEF.md
# Pointer Addressing and Update Unit

This block turns a load, store, program-memory read or push request into a memory address, the matching access strobe, and an optional write-back of an updated pointer. Three 16-bit pointers (X, Y, Z) and the stack pointer arrive as inputs from the register file. The unit picks the base value, applies the addressing mode and holds the address and strobe for the access's fixed number of clocks. In the last clock it pulses `done`, together with the new pointer value when the mode changes a pointer. The register file and memory arrays are outside the block.

A request is sampled on a rising edge with `start` high while the unit is idle. The access occupies the next N clock cycles: N is 2 for data loads, stores and pushes, and 3 for program-memory reads. The outputs return to zero in the cycle after `done`, and only then is a new `start` accepted. A request that the hardware cannot perform is dropped: nothing is strobed and `done` never rises. This covers a displacement on X and the reserved pointer code in a pointer mode.

Top module: `ptr_agu`

## Requirements
- R1: Plain mode (`mode`=0) addresses the selected pointer (`ptr_sel` 0=X, 1=Y, 2=Z) and does no write-back.
- R2: Post-increment mode (`mode`=1) addresses the current pointer. At `done` it writes back pointer+1 to that same pointer (`wb_sel` 0=X, 1=Y, 2=Z).
- R3: Pre-decrement mode (`mode`=2) addresses pointer-1 and writes back that same value to the selected pointer at `done`.
- R4: Displacement mode (`mode`=3) addresses pointer+`disp`, with `disp` unsigned (0..63), and does no write-back. It is legal for Y and Z only. With `ptr_sel`=0, or with `ptr_sel`=3 in any of modes 0..3, the request is dropped: no strobe and no `done`.
- R5: Direct mode (`mode`=4) addresses `direct_addr`, ignores `ptr_sel` and does no write-back.
- R6: Data loads (`is_store`=0) raise `data_rd` and data stores (`is_store`=1) raise `data_wr`, in modes 0..4. The strobe lasts exactly 2 cycles with `mem_addr` held steady. At most one of `data_rd`, `data_wr` and `prog_rd` is high at a time.
- R7: Program reads (`mode`=5, and `mode`=6 with increment) always address Z, ignore `ptr_sel` and `is_store`, and raise `prog_rd` for exactly 3 cycles. Mode 6 writes back Z+1 to Z (`wb_sel`=2).
- R8: Push (`mode`=7) raises `data_wr` at `stack_ptr` for 2 cycles. It writes back `stack_ptr`-1 with `wb_sel`=3.
- R9: All pointer and address arithmetic wraps modulo 2^16.
- R10: `done` is high for exactly the last cycle of each access. `wb_en` is high only in that cycle, and only for modes that update a pointer.
- R11: A `start` while an access is in progress, including its `done` cycle, is ignored. All strobes are low in the cycle after `done`.
- R12: After reset, `mem_addr`, all strobes, `wb_en`, `wb_sel`, `wb_value` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| mode | input | 3 | Addressing mode, codes 0..7 |
| ptr_sel | input | 2 | Pointer select: 0=X, 1=Y, 2=Z, 3=reserved |
| is_store | input | 1 | 1 = store, 0 = load (data modes only) |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Direct address from the instruction |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| stack_ptr | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Access address, held for the whole access |
| data_rd | output | 1 | Data-memory read strobe |
| data_wr | output | 1 | Data-memory write strobe |
| prog_rd | output | 1 | Program-memory read strobe |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Write-back target: 0=X, 1=Y, 2=Z, 3=stack pointer |
| wb_value | output | 16 | Updated pointer value |
| done | output | 1 | Last cycle of the access |

## Verification
The bench drives the wrap points: post-increment and program-read increment from 0xFFFF, pre-decrement and push from 0x0000, and a maximum displacement that carries past 0xFFFF. A unit that kept carries or used signed arithmetic would produce an address or write-back value outside the expected wrapped result. Pre-decrement is checked to address the new value, not the old one. An off-by-one here would read the cell above the pointer. Displacement on X and the reserved pointer code are checked to produce no strobe at all, so a unit that silently used X or zero as the base would be caught. A `start` raised during a push is checked to leave the address and `done` timing unchanged.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  typedef enum logic [2:0] {
    AM_PLAIN    = 3'd0,
    AM_POSTINC  = 3'd1,
    AM_PREDEC   = 3'd2,
    AM_DISP     = 3'd3,
    AM_DIRECT   = 3'd4,
    AM_PROG     = 3'd5,
    AM_PROG_INC = 3'd6,
    AM_PUSH     = 3'd7
  } am_e;

  typedef enum logic [1:0] {
    PS_X   = 2'd0,
    PS_Y   = 2'd1,
    PS_Z   = 2'd2,
    PS_RSV = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    WB_X  = 2'd0,
    WB_Y  = 2'd1,
    WB_Z  = 2'd2,
    WB_SP = 2'd3
  } wbt_e;

  typedef enum logic [1:0] {
    AC_NONE  = 2'd0,
    AC_READ  = 2'd1,
    AC_WRITE = 2'd2,
    AC_PROG  = 2'd3
  } acc_e;

endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux #(
  parameter int AW = 16
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  output logic [AW-1:0] base,
  output logic          base_ok
);
  import ptr_agu_pkg::*;

  localparam int NPTR = 3;

  logic [AW-1:0] bank [NPTR];

  assign bank[0] = ptr_x;
  assign bank[1] = ptr_y;
  assign bank[2] = ptr_z;

  always_comb begin
    base    = '0;
    base_ok = 1'b0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == 2'(i)) begin
        base    = bank[i];
        base_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc #(
  parameter int AW          = 16,
  parameter int QW          = 6,
  parameter int CW          = 2,
  parameter int DATA_CYCLES = 2,
  parameter int PROG_CYCLES = 3,
  parameter int PUSH_CYCLES = 2
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    sel,
  input  logic          is_store,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] direct_addr,
  input  logic [AW-1:0] base,
  input  logic          base_ok,
  input  logic [AW-1:0] ptr_z,
  input  logic [AW-1:0] stack_ptr,
  output logic          legal,
  output logic [AW-1:0] addr,
  output logic [1:0]    kind,
  output logic          wb_req,
  output logic [1:0]    wb_tgt,
  output logic [AW-1:0] wb_val,
  output logic [CW-1:0] cycles
);
  import ptr_agu_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] disp_ext;
  acc_e          data_kind;
  am_e           am;

  assign disp_ext  = AW'(disp);
  assign data_kind = is_store ? AC_WRITE : AC_READ;
  assign am        = am_e'(mode);

  always_comb begin
    legal  = 1'b1;
    addr   = base;
    kind   = data_kind;
    wb_req = 1'b0;
    wb_tgt = sel;
    wb_val = base;
    cycles = CW'(DATA_CYCLES);
    case (am)
      AM_PLAIN: begin
        legal = base_ok;
      end
      AM_POSTINC: begin
        legal  = base_ok;
        wb_req = 1'b1;
        wb_val = base + ONE;
      end
      AM_PREDEC: begin
        legal  = base_ok;
        addr   = base - ONE;
        wb_req = 1'b1;
        wb_val = base - ONE;
      end
      AM_DISP: begin
        legal = base_ok && (sel != PS_X);
        addr  = base + disp_ext;
      end
      AM_DIRECT: begin
        addr = direct_addr;
      end
      AM_PROG: begin
        addr   = ptr_z;
        kind   = AC_PROG;
        cycles = CW'(PROG_CYCLES);
      end
      AM_PROG_INC: begin
        addr   = ptr_z;
        kind   = AC_PROG;
        wb_req = 1'b1;
        wb_tgt = WB_Z;
        wb_val = ptr_z + ONE;
        cycles = CW'(PROG_CYCLES);
      end
      AM_PUSH: begin
        addr   = stack_ptr;
        kind   = AC_WRITE;
        wb_req = 1'b1;
        wb_tgt = WB_SP;
        wb_val = stack_ptr - ONE;
        cycles = CW'(PUSH_CYCLES);
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/agu_seq.sv
module agu_seq #(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          legal,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    kind,
  input  logic          wb_req,
  input  logic [1:0]    wb_tgt,
  input  logic [AW-1:0] wb_val,
  input  logic [CW-1:0] cycles,
  output logic [AW-1:0] mem_addr,
  output logic          data_rd,
  output logic          data_wr,
  output logic          prog_rd,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_value,
  output logic          done
);
  import ptr_agu_pkg::*;

  localparam logic [CW-1:0] C_ONE = CW'(1);

  logic          active;
  logic [CW-1:0] remain;
  logic          wb_pend;
  logic          accept;

  assign accept = start && legal && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      remain   <= '0;
      wb_pend  <= 1'b0;
      mem_addr <= '0;
      data_rd  <= 1'b0;
      data_wr  <= 1'b0;
      prog_rd  <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_value <= '0;
      done     <= 1'b0;
    end else if (!active) begin
      if (accept) begin
        active   <= 1'b1;
        remain   <= cycles - C_ONE;
        wb_pend  <= wb_req;
        mem_addr <= addr;
        data_rd  <= (kind == AC_READ);
        data_wr  <= (kind == AC_WRITE);
        prog_rd  <= (kind == AC_PROG);
        wb_sel   <= wb_tgt;
        wb_value <= wb_val;
        done     <= (cycles == C_ONE);
        wb_en    <= wb_req && (cycles == C_ONE);
      end else begin
        data_rd <= 1'b0;
        data_wr <= 1'b0;
        prog_rd <= 1'b0;
        done    <= 1'b0;
        wb_en   <= 1'b0;
      end
    end else begin
      if (remain == '0) begin
        active  <= 1'b0;
        data_rd <= 1'b0;
        data_wr <= 1'b0;
        prog_rd <= 1'b0;
        done    <= 1'b0;
        wb_en   <= 1'b0;
      end else begin
        remain <= remain - C_ONE;
        if (remain == C_ONE) begin
          done  <= 1'b1;
          wb_en <= wb_pend;
        end
      end
    end
  end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int AW          = 16,
  parameter int QW          = 6,
  parameter int DATA_CYCLES = 2,
  parameter int PROG_CYCLES = 3,
  parameter int PUSH_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [1:0]    ptr_sel,
  input  logic          is_store,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] direct_addr,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  input  logic [AW-1:0] stack_ptr,
  output logic [AW-1:0] mem_addr,
  output logic          data_rd,
  output logic          data_wr,
  output logic          prog_rd,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_value,
  output logic          done
);

  localparam int MAX_A   = (DATA_CYCLES > PUSH_CYCLES) ? DATA_CYCLES : PUSH_CYCLES;
  localparam int MAX_CYC = (MAX_A > PROG_CYCLES) ? MAX_A : PROG_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [AW-1:0] base;
  logic          base_ok;
  logic          legal;
  logic [AW-1:0] addr;
  logic [1:0]    kind;
  logic          wb_req;
  logic [1:0]    wb_tgt;
  logic [AW-1:0] wb_val;
  logic [CW-1:0] cycles;

  agu_ptr_mux #(.AW(AW)) u_mux (
    .sel     (ptr_sel),
    .ptr_x   (ptr_x),
    .ptr_y   (ptr_y),
    .ptr_z   (ptr_z),
    .base    (base),
    .base_ok (base_ok)
  );

  agu_addr_calc #(
    .AW          (AW),
    .QW          (QW),
    .CW          (CW),
    .DATA_CYCLES (DATA_CYCLES),
    .PROG_CYCLES (PROG_CYCLES),
    .PUSH_CYCLES (PUSH_CYCLES)
  ) u_calc (
    .mode        (mode),
    .sel         (ptr_sel),
    .is_store    (is_store),
    .disp        (disp),
    .direct_addr (direct_addr),
    .base        (base),
    .base_ok     (base_ok),
    .ptr_z       (ptr_z),
    .stack_ptr   (stack_ptr),
    .legal       (legal),
    .addr        (addr),
    .kind        (kind),
    .wb_req      (wb_req),
    .wb_tgt      (wb_tgt),
    .wb_val      (wb_val),
    .cycles      (cycles)
  );

  agu_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .legal    (legal),
    .addr     (addr),
    .kind     (kind),
    .wb_req   (wb_req),
    .wb_tgt   (wb_tgt),
    .wb_val   (wb_val),
    .cycles   (cycles),
    .mem_addr (mem_addr),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .prog_rd  (prog_rd),
    .wb_en    (wb_en),
    .wb_sel   (wb_sel),
    .wb_value (wb_value),
    .done     (done)
  );

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int AW          = 16,
  parameter int DATA_CYCLES = 2,
  parameter int PROG_CYCLES = 3,
  parameter int PUSH_CYCLES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          data_rd,
  input logic          data_wr,
  input logic          prog_rd,
  input logic          wb_en,
  input logic [1:0]    wb_sel,
  input logic [AW-1:0] wb_value,
  input logic          done
);

  localparam int RW = 8;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          any_strobe;
  logic [RW-1:0] run_cnt;

  assign any_strobe = data_rd || data_wr || prog_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (!any_strobe) begin
      run_cnt <= '0;
    end else if (run_cnt != {RW{1'b1}}) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_rd, data_wr, prog_rd})); // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (any_strobe && !done) |=> $stable(mem_addr) && any_strobe); // R6

  AST_DATA_LEN: assert property (@(posedge clk) disable iff (rst)
    (done && (data_rd || data_wr)) |->
      (run_cnt == RW'(DATA_CYCLES - 1) || run_cnt == RW'(PUSH_CYCLES - 1))); // R6

  AST_PROG_LEN: assert property (@(posedge clk) disable iff (rst)
    (done && prog_rd) |-> run_cnt == RW'(PROG_CYCLES - 1)); // R7

  AST_PROG_WB: assert property (@(posedge clk) disable iff (rst)
    (wb_en && prog_rd) |-> (wb_sel == 2'd2 && wb_value == mem_addr + ONE)); // R7

  AST_PUSH_WB: assert property (@(posedge clk) disable iff (rst)
    (wb_en && wb_sel == 2'd3) |-> (data_wr && wb_value == mem_addr - ONE)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done); // R10

  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !any_strobe); // R11

endmodule

bind ptr_agu ptr_agu_chk #(
  .AW          (AW),
  .DATA_CYCLES (DATA_CYCLES),
  .PROG_CYCLES (PROG_CYCLES),
  .PUSH_CYCLES (PUSH_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .data_rd  (data_rd),
  .data_wr  (data_wr),
  .prog_rd  (prog_rd),
  .wb_en    (wb_en),
  .wb_sel   (wb_sel),
  .wb_value (wb_value),
  .done     (done)
);

// File: tb/ptr_agu_test.sv
`timescale 1ns/1ps
module ptr_agu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr_sel = '0;
  logic        is_store = 1'b0;
  logic [5:0]  disp = '0;
  logic [15:0] direct_addr = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0, stack_ptr = '0;
  logic [15:0] mem_addr;
  logic        data_rd, data_wr, prog_rd, wb_en, done;
  logic [1:0]  wb_sel;
  logic [15:0] wb_value;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  ptr_agu uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ptr_sel(ptr_sel),
    .is_store(is_store), .disp(disp), .direct_addr(direct_addr),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .stack_ptr(stack_ptr),
    .mem_addr(mem_addr), .data_rd(data_rd), .data_wr(data_wr), .prog_rd(prog_rd),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 read, 2 write, 3 program read
  function automatic logic [2:0] strobe_pat(input int kind);
    case (kind)
      1: return 3'b100;
      2: return 3'b010;
      3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  // Caller is at a falling edge. Launches one request and checks every cycle.
  task automatic do_access(input logic [2:0] m, input logic [1:0] s, input bit st,
                           input logic [5:0] q, input logic [15:0] k,
                           input logic [15:0] exp_addr, input int exp_kind,
                           input int exp_len, input bit exp_wb,
                           input logic [1:0] exp_tgt, input logic [15:0] exp_val,
                           input string req);
    mode = m; ptr_sel = s; is_store = st; disp = q; direct_addr = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_len == 0) begin
      for (int c = 0; c < 3; c++) begin
        chk({data_rd, data_wr, prog_rd, done, wb_en} == 5'b0, req, "dropped request activity",
            {27'b0, data_rd, data_wr, prog_rd, done, wb_en}, 32'h0);
        @(negedge clk);
      end
    end else begin
      for (int c = 1; c <= exp_len; c++) begin
        chk({data_rd, data_wr, prog_rd} == strobe_pat(exp_kind), req, "strobes",
            {29'b0, data_rd, data_wr, prog_rd}, {29'b0, strobe_pat(exp_kind)});
        chk(mem_addr == exp_addr, req, "mem_addr", {16'b0, mem_addr}, {16'b0, exp_addr});
        chk(done == (c == exp_len), req, "done", {31'b0, done}, {31'b0, c == exp_len});
        chk(wb_en == (exp_wb && c == exp_len), req, "wb_en", {31'b0, wb_en},
            {31'b0, exp_wb && c == exp_len});
        if (exp_wb && c == exp_len) begin
          chk(wb_sel == exp_tgt, req, "wb_sel", {30'b0, wb_sel}, {30'b0, exp_tgt});
          chk(wb_value == exp_val, req, "wb_value", {16'b0, wb_value}, {16'b0, exp_val});
        end
        @(negedge clk);
      end
      chk({data_rd, data_wr, prog_rd, done} == 4'b0, "R11", "idle after done",
          {28'b0, data_rd, data_wr, prog_rd, done}, 32'h0);
    end
  endtask

  task automatic t_reset;
    chk(mem_addr == 16'h0, "R12", "mem_addr after reset", {16'b0, mem_addr}, 32'h0);
    chk({data_rd, data_wr, prog_rd, wb_en, done} == 5'b0, "R12", "strobes after reset",
        {27'b0, data_rd, data_wr, prog_rd, wb_en, done}, 32'h0);
    chk({wb_sel, wb_value} == 18'b0, "R12", "write-back after reset",
        {14'b0, wb_sel, wb_value}, 32'h0);
  endtask

  task automatic t_plain;
    ptr_x = 16'h1234; ptr_y = 16'h0456; ptr_z = 16'h7ABC;
    do_access(3'd0, 2'd0, 1'b0, 6'd0, 16'h0, 16'h1234, 1, 2, 1'b0, 2'd0, 16'h0, "R1");
    do_access(3'd0, 2'd1, 1'b1, 6'd0, 16'h0, 16'h0456, 2, 2, 1'b0, 2'd0, 16'h0, "R6");
  endtask

  task automatic t_postinc;
    ptr_y = 16'h0100; ptr_z = 16'h2000; ptr_x = 16'hFFFF;
    do_access(3'd1, 2'd1, 1'b0, 6'd0, 16'h0, 16'h0100, 1, 2, 1'b1, 2'd1, 16'h0101, "R2");
    do_access(3'd1, 2'd2, 1'b1, 6'd0, 16'h0, 16'h2000, 2, 2, 1'b1, 2'd2, 16'h2001, "R2");
    do_access(3'd1, 2'd0, 1'b0, 6'd0, 16'h0, 16'hFFFF, 1, 2, 1'b1, 2'd0, 16'h0000, "R9");
  endtask

  task automatic t_predec;
    ptr_z = 16'h0800; ptr_x = 16'h0000;
    do_access(3'd2, 2'd2, 1'b0, 6'd0, 16'h0, 16'h07FF, 1, 2, 1'b1, 2'd2, 16'h07FF, "R3");
    do_access(3'd2, 2'd0, 1'b1, 6'd0, 16'h0, 16'hFFFF, 2, 2, 1'b1, 2'd0, 16'hFFFF, "R9");
  endtask

  task automatic t_disp;
    ptr_y = 16'h0300; ptr_z = 16'hFFF0; ptr_x = 16'h5555;
    do_access(3'd3, 2'd1, 1'b0, 6'd0, 16'h0, 16'h0300, 1, 2, 1'b0, 2'd0, 16'h0, "R4");
    do_access(3'd3, 2'd1, 1'b1, 6'd20, 16'h0, 16'h0314, 2, 2, 1'b0, 2'd0, 16'h0, "R4");
    do_access(3'd3, 2'd2, 1'b0, 6'd63, 16'h0, 16'h002F, 1, 2, 1'b0, 2'd0, 16'h0, "R9");
  endtask

  task automatic t_reject;
    do_access(3'd3, 2'd0, 1'b0, 6'd5, 16'h0, 16'h0, 0, 0, 1'b0, 2'd0, 16'h0, "R4");
    do_access(3'd1, 2'd3, 1'b1, 6'd0, 16'h0, 16'h0, 0, 0, 1'b0, 2'd0, 16'h0, "R4");
  endtask

  task automatic t_direct;
    do_access(3'd4, 2'd3, 1'b1, 6'd9, 16'hBEEF, 16'hBEEF, 2, 2, 1'b0, 2'd0, 16'h0, "R5");
    do_access(3'd4, 2'd0, 1'b0, 6'd0, 16'h0042, 16'h0042, 1, 2, 1'b0, 2'd0, 16'h0, "R5");
  endtask

  task automatic t_prog;
    ptr_x = 16'h1111; ptr_z = 16'h0A0A;
    do_access(3'd5, 2'd0, 1'b1, 6'd0, 16'h0, 16'h0A0A, 3, 3, 1'b0, 2'd0, 16'h0, "R7");
    ptr_z = 16'hFFFF;
    do_access(3'd6, 2'd1, 1'b0, 6'd0, 16'h0, 16'hFFFF, 3, 3, 1'b1, 2'd2, 16'h0000, "R7");
  endtask

  task automatic t_push;
    stack_ptr = 16'h08FF;
    do_access(3'd7, 2'd0, 1'b0, 6'd0, 16'h0, 16'h08FF, 2, 2, 1'b1, 2'd3, 16'h08FE, "R8");
    stack_ptr = 16'h0000;
    do_access(3'd7, 2'd2, 1'b0, 6'd0, 16'h0, 16'h0000, 2, 2, 1'b1, 2'd3, 16'hFFFF, "R9");
  endtask

  task automatic t_busy;
    stack_ptr = 16'h0100;
    mode = 3'd7; start = 1'b1;
    @(negedge clk);
    mode = 3'd4; direct_addr = 16'h1234; is_store = 1'b1;   // second start, cycle 1
    chk(mem_addr == 16'h0100, "R11", "addr cycle 1", {16'b0, mem_addr}, 32'h0100);
    @(negedge clk);
    chk(mem_addr == 16'h0100 && done, "R11", "addr/done cycle 2 with start held",
        {15'b0, done, mem_addr}, {15'b0, 1'b1, 16'h0100});
    start = 1'b0;
    @(negedge clk);
    chk({data_rd, data_wr, prog_rd, done} == 4'b0, "R11", "no access from ignored start",
        {28'b0, data_rd, data_wr, prog_rd, done}, 32'h0);
    @(negedge clk);
    chk({data_rd, data_wr, prog_rd, done} == 4'b0, "R11", "still idle",
        {28'b0, data_rd, data_wr, prog_rd, done}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_postinc();
    t_predec();
    t_disp();
    t_reject();
    t_direct();
    t_prog();
    t_push();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule